// File: doc/BRIEF.md
# Integer ALU with Operation Decode

This block is the arithmetic/logic stage of a simple single-issue integer datapath. It is purely combinational. A small decoder turns a 2-bit operation class and a 6-bit function field into a 4-bit operation select. The datapath applies that select to two 32-bit operands and produces a 32-bit result, a zero flag and an overflow flag.

Addition and subtraction share one ripple-carry chain. For subtraction the second operand is inverted and a carry of one is fed in at bit 0. Set-on-less-than runs the same subtraction and reports only the sign of the difference, in bit 0. The zero flag serves equality branches. The overflow flag compares the carry entering the top bit with the carry leaving it. An operand-signedness input silences the overflow flag for unsigned arithmetic. Class and function codes that do not map to an operation are flagged as illegal.

Top module: `int_alu`

## Requirements
- R1: Operation class 2'b00 selects add (select 4'b0010) for every function field value, with illegal low.
- R2: Operation class 2'b01 selects subtract (select 4'b0110) for every function field value, with illegal low.
- R3: Operation class 2'b10 decodes the function field as follows: 6'b100000 gives add, 6'b100010 gives subtract, 6'b100100 gives AND, 6'b100101 gives OR, 6'b100111 gives NOR and 6'b101010 gives set-on-less-than.
- R4: The select output uses these codes: 4'b0000 AND, 4'b0001 OR, 4'b0010 add, 4'b0110 subtract, 4'b0111 set-on-less-than, 4'b1100 NOR. The result is a&b, a|b or ~(a|b) for the three bitwise codes.
- R5: Add returns (a + b) modulo 2^32.
- R6: Subtract returns (a - b) modulo 2^32, which is a + ~b + 1.
- R7: Set-on-less-than returns bit 31 of (a - b) modulo 2^32 in result bit 0, with all other result bits 0.
- R8: The zero output is 1 exactly when all 32 result bits are 0. It is always 1 for a subtract of equal operands.
- R9: With signed_op high, overflow is 1 exactly when an add or subtract result has the wrong sign for the true two's-complement value.
- R10: With signed_op low, overflow is 0 for every operation.
- R11: For AND, OR, NOR, set-on-less-than and illegal codes, overflow is 0.
- R12: Operation class 2'b11, or class 2'b10 with any function value not listed in R3, sets illegal high, gives select 4'b0000 and performs AND.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class: memory address, branch compare, register function, reserved |
| funct | input | 6 | Function field, decoded only in the register class |
| signed_op | input | 1 | 1 = signed arithmetic, so overflow may be reported |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| alu_sel | output | 4 | Decoded operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add/subtract |
| illegal | output | 1 | High for an unmapped class or function code |

## Verification
The hardest case to reach is set-on-less-than where the subtraction overflows. There the sign of the wrapped difference disagrees with the true signed order, and the result must still follow the sign bit. Random operands rarely produce this. The stimulus therefore crosses every pair of the corner operands 0, 1, -1, the most negative and the most positive value with every operation, in both signedness settings. Pairs such as most-negative minus one then force both directions of overflow, the wrapped comparison, and equal-operand subtractions that raise zero.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;
    localparam int SEL_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111,
        SEL_NOR = 4'b1100
    } alu_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_RSVD   = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_NOR = 6'b100111;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef struct packed {
        alu_sel_e sel;
        logic     illegal;
    } dec_t;

    // Operations whose signed overflow is meaningful.
    function automatic logic sel_is_arith(alu_sel_e s);
        return (s == SEL_ADD) || (s == SEL_SUB);
    endfunction

    // Operations that run the adder in subtract mode.
    function automatic logic sel_uses_sub(alu_sel_e s);
        return (s == SEL_SUB) || (s == SEL_SLT);
    endfunction

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
    import int_alu_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output dec_t               dec
);

    always_comb begin
        dec.sel     = SEL_AND;
        dec.illegal = 1'b0;
        unique case (op_class)
            CLS_MEM:    dec.sel = SEL_ADD;
            CLS_BRANCH: dec.sel = SEL_SUB;
            CLS_REG: begin
                unique case (funct)
                    FN_ADD:  dec.sel = SEL_ADD;
                    FN_SUB:  dec.sel = SEL_SUB;
                    FN_AND:  dec.sel = SEL_AND;
                    FN_OR:   dec.sel = SEL_OR;
                    FN_NOR:  dec.sel = SEL_NOR;
                    FN_SLT:  dec.sel = SEL_SLT;
                    default: dec.illegal = 1'b1;
                endcase
            end
            default: dec.illegal = 1'b1;
        endcase
    end

    // Class-level decode checks
    always_comb begin
        if (op_class == 2'b00) begin
            a_r1_mem_adds : assert (dec.sel == SEL_ADD && !dec.illegal);
        end
        if (op_class == 2'b01) begin
            a_r2_branch_subs : assert (dec.sel == SEL_SUB && !dec.illegal);
        end
        if (op_class == 2'b11) begin
            a_r12_rsvd_illegal : assert (dec.illegal && dec.sel == SEL_AND);
        end
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_into_msb,
    output logic             carry_out
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    assign b_eff    = b ^ {WIDTH{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (a[i] & carry[i]) | (b_eff[i] & carry[i]);
    end

    assign carry_into_msb = carry[WIDTH-1];
    assign carry_out      = carry[WIDTH];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_sel_e         sel,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (sel)
            SEL_OR:  y = a | b;
            SEL_NOR: y = ~(a | b);
            default: y = a & b;
        endcase
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       funct,
    input  logic             signed_op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [3:0]       alu_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             illegal
);

    localparam int MSB = WIDTH - 1;

    dec_t             dec;
    logic [WIDTH-1:0] arith_sum;
    logic [WIDTH-1:0] logic_y;
    logic             c_msb_in;
    logic             c_msb_out;

    alu_ctrl_decode u_dec (
        .op_class (op_class),
        .funct    (funct),
        .dec      (dec)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_adder (
        .a              (a),
        .b              (b),
        .sub            (sel_uses_sub(dec.sel)),
        .sum            (arith_sum),
        .carry_into_msb (c_msb_in),
        .carry_out      (c_msb_out)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_logic (
        .a   (a),
        .b   (b),
        .sel (dec.sel),
        .y   (logic_y)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_ADD, SEL_SUB: result = arith_sum;
            SEL_SLT:          result = {{(WIDTH-1){1'b0}}, arith_sum[MSB]};
            default:          result = logic_y;
        endcase
    end

    assign alu_sel  = dec.sel;
    assign illegal  = dec.illegal;
    assign zero     = ~|result;
    assign overflow = signed_op & sel_is_arith(dec.sel) & (c_msb_in ^ c_msb_out);

    // Output relations across decoder, adder and flags
    always_comb begin
        if (dec.sel == SEL_SLT) begin
            a_r7_slt_upper_clear : assert (result[MSB:1] == '0);
        end
        if (dec.sel == SEL_SUB && a == b) begin
            a_r8_equal_sub_zero : assert (zero);
        end
        if (!signed_op) begin
            a_r10_unsigned_no_overflow : assert (!overflow);
        end
        if (dec.sel != SEL_ADD && dec.sel != SEL_SUB) begin
            a_r11_nonarith_no_overflow : assert (!overflow);
        end
        if (illegal) begin
            a_r12_illegal_is_and : assert (alu_sel == 4'b0000 && result == (a & b));
        end
    end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_class = 2'b00;
    logic [5:0]  funct = 6'd0;
    logic        signed_op = 1'b0;
    logic [31:0] a = 32'd0;
    logic [31:0] b = 32'd0;
    logic [3:0]  alu_sel;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    int_alu uut (
        .op_class  (op_class),
        .funct     (funct),
        .signed_op (signed_op),
        .a         (a),
        .b         (b),
        .alu_sel   (alu_sel),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .illegal   (illegal)
    );

    typedef struct {
        logic [3:0]  sel;
        logic [31:0] res;
        logic        zf;
        logic        ovf;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply stimulus and push the independently computed expectation
    task automatic drive(input logic [1:0] cls, input logic [5:0] fn, input logic sgn,
                         input logic [31:0] x, input logic [31:0] y, input string tag);
        exp_t e;
        logic [31:0] s, d;
        @(negedge clk);
        op_class = cls; funct = fn; signed_op = sgn; a = x; b = y;
        e.ill = 1'b0;
        case (cls)
            2'b00: e.sel = 4'b0010;
            2'b01: e.sel = 4'b0110;
            2'b10: begin
                case (fn)
                    6'b100000: e.sel = 4'b0010;
                    6'b100010: e.sel = 4'b0110;
                    6'b100100: e.sel = 4'b0000;
                    6'b100101: e.sel = 4'b0001;
                    6'b100111: e.sel = 4'b1100;
                    6'b101010: e.sel = 4'b0111;
                    default: begin e.sel = 4'b0000; e.ill = 1'b1; end
                endcase
            end
            default: begin e.sel = 4'b0000; e.ill = 1'b1; end
        endcase
        s = x + y;
        d = x - y;
        e.ovf = 1'b0;
        case (e.sel)
            4'b0010: begin
                e.res = s;
                e.ovf = sgn && (x[31] == y[31]) && (s[31] != x[31]);
            end
            4'b0110: begin
                e.res = d;
                e.ovf = sgn && (x[31] != y[31]) && (d[31] != x[31]);
            end
            4'b0111: e.res = {31'd0, d[31]};
            4'b0001: e.res = x | y;
            4'b1100: e.res = ~(x | y);
            default: e.res = x & y;
        endcase
        e.zf  = (e.res == 32'd0);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the following rising edge, mid-way through the input window
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " R4 select"}, {28'd0, alu_sel}, {28'd0, e.sel});
            check({e.tag, " result"}, result, e.res);
            check({e.tag, " R8 zero"}, {31'd0, zero}, {31'd0, e.zf});
            check({e.tag, " R9 overflow"}, {31'd0, overflow}, {31'd0, e.ovf});
            check({e.tag, " R12 illegal"}, {31'd0, illegal}, {31'd0, e.ill});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [5];
        logic [5:0]  fns [6];
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF;
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b100111; fns[5] = 6'b101010;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset-state pattern: all-zero inputs give add of zeros
        drive(2'b00, 6'd0, 1'b0, 32'd0, 32'd0, "R1 reset");

        // Corner operand crossings through every register-class operation
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 6; f++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        drive(2'b10, fns[f], s[0], corner[i], corner[j], "R3 R5 R6 R7 R10 R11 corner");

        // Specific boundary cases
        drive(2'b10, 6'b100000, 1'b1, 32'h7FFF_FFFF, 32'd1, "R9 add pos overflow");
        drive(2'b10, 6'b100000, 1'b0, 32'h7FFF_FFFF, 32'd1, "R10 add unsigned");
        drive(2'b10, 6'b100010, 1'b1, 32'h8000_0000, 32'd1, "R9 sub neg overflow");
        drive(2'b10, 6'b101010, 1'b1, 32'h8000_0000, 32'd1, "R7 slt wrapped sign");
        drive(2'b01, 6'b100000, 1'b1, 32'h1234_5678, 32'h1234_5678, "R2 R8 equal branch");
        drive(2'b10, 6'b100111, 1'b1, 32'hFFFF_FFFF, 32'd0, "R4 nor all zero");

        // Class 00 and 01 ignore the function field
        for (int k = 0; k < 64; k++) begin
            drive(2'b00, k[5:0], 1'b1, $urandom, $urandom, "R1 mem class");
            drive(2'b01, k[5:0], 1'b1, $urandom, $urandom, "R2 branch class");
            drive(2'b11, k[5:0], 1'b1, $urandom, $urandom, "R12 reserved class");
            drive(2'b10, k[5:0], 1'b1, $urandom, $urandom, "R3 R12 funct sweep");
        end

        // Random operands across all operations
        for (int k = 0; k < 300; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (k % 7 == 0) ? ra : $urandom;
            drive(2'b10, fns[k % 6], k[0], ra, rb, "R5 R6 R7 R9 random");
        end

        @(negedge clk);
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule